// File: doc/BRIEF.md
# Burst Cache-Line Fill Controller

This block moves one cache line of four words between a processor cache and a memory that supports page-mode or static-column access. The cache presents a single address together with a direction: fill the line from memory, or write the line out to memory. The block then runs the whole transfer. It produces the addresses of words two to four itself, drives the memory strobes, and returns each fetched word with its slot index. A one-cycle completion pulse marks the end of the transfer.

In burst mode, the first word occupies the memory for two clocks and each later word for one clock, so the line needs five memory clocks. A non-burst mode is also provided for comparison. In that mode every word is a separate three-clock access, so the line needs twelve memory clocks. Both directions follow the same sequencing.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole transfer, so a request held during that time waits and is never taken mid-line. The returned word stream has no ready input and cannot be back-pressured, because the memory timing is fixed. The consumer must take each word in the cycle where `rd_valid` is high.

Top module: `burst_line_fill`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle after that edge: `busy`, `rd_valid`, `done`, `mem_en`, `mem_we`, `mem_end` and `mem_page` are low and `req_ready` is high.
- R2: Every accepted request transfers exactly four words. A fill produces exactly four `rd_valid` cycles.
- R3: In burst mode, `mem_en` is high for exactly five cycles, starting in the cycle after acceptance. `done` is high in the sixth cycle after the accepting edge.
- R4: The two low bits of `req_addr` are ignored. The line base is `req_addr` with those bits cleared. Word k, with k running 0 to 3, is accessed at the base with k in the low two bits, and the upper bits stay unchanged.
- R5: In non-burst mode, every word is a three-cycle access. `mem_en` is high for twelve cycles, and `done` is high in the thirteenth cycle after the accepting edge.
- R6: A write-out (`req_write`=1) drives `mem_we` high during the access. In the final cycle of word k's access (`mem_end` high), `mem_wdata` equals bits [k*32 +: 32] of `req_wline` as captured at acceptance.
- R7: `busy` is high and `req_ready` is low from the cycle after acceptance through the cycle of `done`. A request presented during that time is not accepted.
- R8: `done` is a one-cycle pulse. On a fill it coincides with the fourth `rd_valid`, and `rd_idx` is 3 in that cycle.
- R9: On a fill, the word whose access ends with `mem_end` in cycle t is latched from `mem_rdata`. It is presented in cycle t+1 on `rd_data`, with `rd_idx` giving its index, in the order 0, 1, 2, 3.
- R10: A reset asserted in the middle of a transfer abandons it. No further words, strobes or `done` follow.
- R11: `mem_page` is high in every access cycle of burst words 1 to 3. It is low for word 0 and throughout non-burst mode.
- R12: A write-out never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line request offered |
| req_ready | output | 1 | Block can take a request (idle) |
| req_addr | input | AW | Word address of the line; low two bits ignored |
| req_write | input | 1 | 1 = write the line out, 0 = fill the line |
| req_burst | input | 1 | 1 = burst timing, 0 = separate three-clock accesses |
| req_wline | input | WORDS*DW | Line to write; word k at bits [k*DW +: DW] |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_valid | output | 1 | Fetched word present on rd_data |
| rd_data | output | DW | Latched fetched word |
| rd_idx | output | IW | Slot index of the presented word |
| mem_en | output | 1 | Memory access cycle |
| mem_we | output | 1 | Access is a write |
| mem_end | output | 1 | Final cycle of the current word's access |
| mem_page | output | 1 | Follow-on word within the open page |
| mem_addr | output | AW | Word address of the current access |
| mem_wdata | output | DW | Write data of the current word |
| mem_rdata | input | DW | Read data, sampled when mem_end is high |

## Verification
The bench offers a request address with the low bits set and checks every generated address. A design that used the raw address, or carried into the upper bits, would access the wrong words. Both timing modes are measured from the accepting edge. An off-by-one word counter would show up as a wrong `done` cycle or a fifth word, and timing tied to the wrong mode would show up as five clocks where twelve are expected. A request is held high during a transfer. A design that accepted it would restart mid-line and emit extra words. A written line is read back through a burst fill, which catches a slice of the wrong `req_wline` word, and a reset in the middle of an access must leave no stray word or pulse behind.

// File: rtl/blf_pkg.sv
package blf_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACC  = 2'd1,
    SEQ_TAIL = 2'd2
  } seq_st_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/blf_req_latch.sv
module blf_req_latch #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic [AW-1:0]       req_addr,
  input  logic                req_write,
  input  logic                req_burst,
  input  logic [WORDS*DW-1:0] req_wline,
  input  logic [IW-1:0]       widx,
  output logic                wr_q,
  output logic                burst_q,
  output logic [AW-1:0]       word_addr,
  output logic [DW-1:0]       word_wdata
);

  logic [AW-IW-1:0]    base_q;
  logic [WORDS*DW-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      line_q  <= '0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
    end else if (take) begin
      base_q  <= req_addr[AW-1:IW];
      line_q  <= req_write ? req_wline : '0;
      wr_q    <= req_write;
      burst_q <= req_burst;
    end
  end

  // Upper bits fixed for the line, word index fills the low bits.
  assign word_addr  = {base_q, widx};
  assign word_wdata = line_q[widx*DW +: DW];

endmodule

// File: rtl/blf_seq.sv
module blf_seq
  import blf_pkg::*;
#(
  parameter int WORDS      = 4,
  parameter int FIRST_LAT  = 2,
  parameter int NEXT_LAT   = 1,
  parameter int SINGLE_LAT = 3,
  localparam int IW        = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_burst,
  input  logic          run_burst,
  output logic          busy,
  output logic          active,
  output logic          word_end,
  output logic          last_word,
  output logic          page,
  output logic [IW-1:0] widx
);

  localparam int MAXL           = max3(FIRST_LAT, NEXT_LAT, SINGLE_LAT);
  localparam int CW             = (MAXL > 1) ? $clog2(MAXL) : 1;
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  seq_st_t       st_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] lat_m1(input logic b, input logic first);
    int l;
    l = b ? (first ? FIRST_LAT : NEXT_LAT) : SINGLE_LAT;
    return CW'(l - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      widx  <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (start) begin
            st_q  <= SEQ_ACC;
            widx  <= '0;
            cnt_q <= lat_m1(start_burst, 1'b1);
          end
        end
        SEQ_ACC: begin
          if (cnt_q == '0) begin
            if (widx == LAST) begin
              st_q <= SEQ_TAIL;
            end else begin
              widx  <= widx + 1'b1;
              cnt_q <= lat_m1(run_burst, 1'b0);
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_TAIL: st_q <= SEQ_IDLE;
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != SEQ_IDLE);
  assign active    = (st_q == SEQ_ACC);
  assign word_end  = active && (cnt_q == '0);
  assign last_word = (widx == LAST);
  assign page      = active && run_burst && (widx != '0);

endmodule

// File: rtl/blf_rdpath.sv
module blf_rdpath #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_end,
  input  logic          last_word,
  input  logic          is_write,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] mem_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [IW-1:0] rd_idx,
  output logic          done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
      rd_idx   <= '0;
    end else begin
      rd_valid <= word_end && !is_write;
      done     <= word_end && last_word;
      if (word_end) begin
        rd_idx <= widx;
      end
      if (word_end && !is_write) begin
        rd_data <= mem_rdata;
      end
    end
  end

endmodule

// File: rtl/burst_line_fill.sv
module burst_line_fill #(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int WORDS      = 4,
  parameter int FIRST_LAT  = 2,
  parameter int NEXT_LAT   = 1,
  parameter int SINGLE_LAT = 3,
  localparam int IW        = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_addr,
  input  logic                req_write,
  input  logic                req_burst,
  input  logic [WORDS*DW-1:0] req_wline,
  output logic                busy,
  output logic                done,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic [IW-1:0]       rd_idx,
  output logic                mem_en,
  output logic                mem_we,
  output logic                mem_end,
  output logic                mem_page,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata
);

  logic          take;
  logic          wr_q;
  logic          burst_q;
  logic          active;
  logic          last_word;
  logic [IW-1:0] widx;
  logic [DW-1:0] word_wdata;

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;

  blf_req_latch #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_req (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_burst  (req_burst),
    .req_wline  (req_wline),
    .widx       (widx),
    .wr_q       (wr_q),
    .burst_q    (burst_q),
    .word_addr  (mem_addr),
    .word_wdata (word_wdata)
  );

  blf_seq #(
    .WORDS(WORDS), .FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT), .SINGLE_LAT(SINGLE_LAT)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (take),
    .start_burst (req_burst),
    .run_burst   (burst_q),
    .busy        (busy),
    .active      (active),
    .word_end    (mem_end),
    .last_word   (last_word),
    .page        (mem_page),
    .widx        (widx)
  );

  blf_rdpath #(.DW(DW), .WORDS(WORDS)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .word_end  (mem_end),
    .last_word (last_word),
    .is_write  (wr_q),
    .widx      (widx),
    .mem_rdata (mem_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .done      (done)
  );

  assign mem_en    = active;
  assign mem_we    = active && wr_q;
  assign mem_wdata = mem_we ? word_wdata : '0;

endmodule

// File: rtl/blf_chk.sv
module blf_chk #(
  parameter int AW         = 16,
  parameter int WORDS      = 4,
  parameter int FIRST_LAT  = 2,
  parameter int NEXT_LAT   = 1,
  parameter int SINGLE_LAT = 3,
  localparam int IW        = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_burst,
  input logic          busy,
  input logic          done,
  input logic          rd_valid,
  input logic [IW-1:0] rd_idx,
  input logic          mem_en,
  input logic          mem_we,
  input logic          mem_end,
  input logic          mem_page,
  input logic [AW-1:0] mem_addr
);

  localparam int BURST_CLK  = FIRST_LAT + (WORDS - 1) * NEXT_LAT;
  localparam int SINGLE_CLK = WORDS * SINGLE_LAT;

  logic [15:0] en_cnt;
  logic        burst_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_cnt  <= '0;
      burst_l <= 1'b0;
    end else if (req_valid && req_ready) begin
      en_cnt  <= '0;
      burst_l <= req_burst;
    end else if (mem_en) begin
      en_cnt <= en_cnt + 1'b1;
    end
  end

  assert_accept_starts_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (busy && mem_en && !req_ready));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_en && $past(mem_en) && $past(mem_end)) |->
      ((mem_addr[IW-1:0] == IW'($past(mem_addr[IW-1:0]) + 1'b1)) &&
       (mem_addr[AW-1:IW] == $past(mem_addr[AW-1:IW]))));

  assert_line_length_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (en_cnt == 16'(burst_l ? BURST_CLK : SINGLE_CLK)));

  assert_done_last_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(mem_end) && (rd_idx == IW'(WORDS - 1))));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_page_follow_R11: assert property (@(posedge clk) disable iff (rst)
    mem_page |-> (mem_en && (mem_addr[IW-1:0] != '0)));

  assert_valid_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);

  assert_write_silent_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_end && mem_we) |=> !rd_valid);

endmodule

bind burst_line_fill blf_chk #(
  .AW(AW), .WORDS(WORDS), .FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT), .SINGLE_LAT(SINGLE_LAT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_burst (req_burst),
  .busy      (busy),
  .done      (done),
  .rd_valid  (rd_valid),
  .rd_idx    (rd_idx),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_end   (mem_end),
  .mem_page  (mem_page),
  .mem_addr  (mem_addr)
);

// File: tb/burst_line_fill_tb.sv
module burst_line_fill_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int WORDS = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic req_burst = 1'b0;
  logic [WORDS*DW-1:0] req_wline = '0;
  logic busy, done, rd_valid, mem_en, mem_we, mem_end, mem_page;
  logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
  logic [IW-1:0] rd_idx;
  logic [AW-1:0] mem_addr;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  bit            written [64];
  logic [DW-1:0] wmem    [64];
  logic [DW-1:0] exp_d [$];
  logic [IW-1:0] exp_i [$];

  always #4 clk = ~clk;

  burst_line_fill u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_burst(req_burst),
    .req_wline(req_wline), .busy(busy), .done(done), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_idx(rd_idx), .mem_en(mem_en), .mem_we(mem_we),
    .mem_end(mem_end), .mem_page(mem_page), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    if (written[a[5:0]]) return wmem[a[5:0]];
    return 32'h5A00_0000 + 32'(a) * 32'h0001_0203;
  endfunction

  assign mem_rdata = memval(mem_addr);

  always @(posedge clk) begin
    if (mem_end && mem_we) begin
      written[mem_addr[5:0]] <= 1'b1;
      wmem[mem_addr[5:0]]    <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard whenever a fetched word appears.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R2 unexpected extra word", 64'(rd_data), 64'h0);
      end else begin
        logic [DW-1:0] ed;
        logic [IW-1:0] ei;
        ed = exp_d.pop_front();
        ei = exp_i.pop_front();
        chk(rd_data == ed, "R9 word data", 64'(rd_data), 64'(ed));
        chk(rd_idx == ei, "R9 word index", 64'(rd_idx), 64'(ei));
      end
    end
  end

  // Driver: pushes expectations, issues one request and follows it to done.
  task automatic run_op(input logic [AW-1:0] addr, input bit wr, input bit bst,
                        input logic [WORDS*DW-1:0] line, input bit poke_busy);
    logic [AW-1:0] base;
    int n, en_cycles, k, vcnt;
    base = {addr[AW-1:2], 2'b00};
    if (!wr) begin
      for (int i = 0; i < WORDS; i++) begin
        exp_d.push_back(memval(base | AW'(i)));
        exp_i.push_back(IW'(i));
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready when idle", 64'(req_ready), 64'h1);
    req_addr = addr; req_write = wr; req_burst = bst; req_wline = line; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_addr = '0; req_wline = '0;
    n = 1; en_cycles = 0; k = 0; vcnt = 0;
    while (n < 40) begin
      if (poke_busy && n == 2) begin
        req_valid = 1'b1; req_addr = 16'h0038; req_write = 1'b0; req_burst = 1'b0;
        chk(req_ready == 1'b0 && busy == 1'b1, "R7 ready low while busy", 64'(req_ready), 64'h0);
      end
      if (poke_busy && n == 4) req_valid = 1'b0;
      if (rd_valid) vcnt++;
      if (mem_en) begin
        en_cycles++;
        chk(mem_page == (bst && k != 0), "R11 page strobe", 64'(mem_page), 64'(bst && k != 0));
        chk(mem_we == wr, "R6 write enable", 64'(mem_we), 64'(wr));
      end
      if (wr) chk(rd_valid == 1'b0, "R12 no word on write-out", 64'(rd_valid), 64'h0);
      if (mem_end) begin
        chk(mem_addr == (base | AW'(k)), "R4 word address", 64'(mem_addr), 64'(base | AW'(k)));
        if (wr) chk(mem_wdata == line[k*DW +: DW], "R6 write data", 64'(mem_wdata), 64'(line[k*DW +: DW]));
        k++;
      end
      if (done) break;
      n++;
      @(negedge clk);
    end
    if (bst) begin
      chk(n == 6, "R3 burst done cycle", 64'(n), 64'd6);
      chk(en_cycles == 5, "R3 burst memory clocks", 64'(en_cycles), 64'd5);
    end else begin
      chk(n == 13, "R5 non-burst done cycle", 64'(n), 64'd13);
      chk(en_cycles == 12, "R5 non-burst memory clocks", 64'(en_cycles), 64'd12);
    end
    chk(k == 4, "R2 four words accessed", 64'(k), 64'd4);
    if (!wr) begin
      chk(rd_valid == 1'b1 && rd_idx == 2'd3, "R8 done with fourth word", 64'({rd_valid, rd_idx}), 64'h7);
      chk(vcnt == 4, "R2 four words returned", 64'(vcnt), 64'd4);
    end
    chk(busy == 1'b1, "R7 busy through done", 64'(busy), 64'h1);
    @(negedge clk);
    chk(done == 1'b0 && rd_valid == 1'b0, "R8 done single pulse", 64'({done, rd_valid}), 64'h0);
    chk(busy == 1'b0 && mem_en == 1'b0, "R7 idle after line", 64'({busy, mem_en}), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [WORDS*DW-1:0] line;
    repeat (3) @(negedge clk);
    chk(busy == 0 && rd_valid == 0 && done == 0 && mem_en == 0 && mem_end == 0 &&
        mem_we == 0 && mem_page == 0 && req_ready == 1, "R1 reset state",
        64'({busy, rd_valid, done, mem_en, mem_end, mem_we, mem_page, req_ready}), 64'h1);
    rst = 1'b0;

    run_op(16'h0013, 1'b0, 1'b1, '0, 1'b0);   // R4: low bits set, must be ignored
    run_op(16'h0024, 1'b0, 1'b1, '0, 1'b1);   // R7: request held during line
    repeat (3) @(negedge clk);
    chk(mem_en == 1'b0 && exp_d.size() == 0, "R7 held request not taken", 64'(mem_en), 64'h0);
    run_op(16'h0008, 1'b0, 1'b0, '0, 1'b0);   // R5 non-burst fill

    line = {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};
    run_op(16'h0031, 1'b1, 1'b1, line, 1'b0); // R6 burst write-out
    run_op(16'h0030, 1'b0, 1'b1, '0, 1'b0);   // read the written line back
    line = {32'h1357_9BDF, 32'h2468_ACE0, 32'h0F0F_F0F0, 32'hFEED_BEEF};
    run_op(16'h0006, 1'b1, 1'b0, line, 1'b0); // non-burst write-out
    run_op(16'h0004, 1'b0, 1'b0, '0, 1'b0);

    // R10: reset in the middle of a non-burst fill
    @(negedge clk);
    req_addr = 16'h0010; req_write = 1'b0; req_burst = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mem_en == 0 && rd_valid == 0 && done == 0 && req_ready == 1,
        "R10 reset abandons line", 64'({busy, mem_en, rd_valid, done, req_ready}), 64'h1);
    rst = 1'b0;
    repeat (12) begin
      @(negedge clk);
      chk(mem_en == 0 && rd_valid == 0 && done == 0, "R10 nothing after reset",
          64'({mem_en, rd_valid, done}), 64'h0);
    end
    run_op(16'h003C, 1'b0, 1'b1, '0, 1'b0);
    repeat (2) @(negedge clk);
    chk(exp_d.size() == 0, "R2 all expected words seen", 64'(exp_d.size()), 64'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule